// File: doc/BRIEF.md
# Flash Erase Command Controller

This block is the erase part of a parallel NOR flash command interface, placed in front of a behavioural memory array. It decodes six-write bus command sequences into two requests. One erases the whole chip. The other erases a list of blocks. For a block erase it builds a bitmap of selected blocks. Further blocks can be added by repeating only the final command write while a selection window is open. Each addition restarts that window.

When the window expires, or at once for a chip erase, the controller takes the current protect bits and starts. It walks the blocks in ascending order and sets every word of each unprotected selected block to all ones. Protected blocks are skipped without any error. If nothing is left to erase, the controller stays busy for a short dwell time and then finishes with the data unchanged.

While a request is in progress, reads return a status word instead of array data. A completed erase returns to array reads on its own. A reported erase failure holds the error status until a reset command is written.

Top module: `flash_erase_ctrl`

## Requirements
- R1: A command needs six writes (address/data): 0x2A/0xAA, 0x15/0x55, 0x2A/0x80, 0x2A/0xAA, 0x15/0x55, then 0x2A/0x10 for chip erase or <any address in the block>/0x30 for block erase. The block index is the top log2(NUM_BLK) address bits.
- R2: A write whose address or data differs from the expected value in any of the six cycles abandons the sequence. The block stays in array-read mode with busy_o low.
- R3: During selection, each write with data 0x30 adds the addressed block and restarts the window. The erase starts exactly SEL_CYC clock cycles after the last selecting write.
- R4: After the erase has started, writes of 0x30 add no blocks.
- R5: The protect bits are sampled when the erase starts. Protected blocks are skipped without error, every other selected block reads all ones afterwards, and unselected blocks keep their data.
- R6: If every targeted block is protected, busy_o stays high for exactly EMPTY_CYC cycles after the start. The block then returns to array reads with data unchanged and no error.
- R7: A chip erase starts on its sixth write and targets every unprotected block. While it runs, every write is ignored, including 0xF0 and 0xB0.
- R8: During block-erase selection or execution, a write of 0xB0 makes suspend_req_o high for one cycle, and the erase continues. Other writes (0xF0 included) are ignored.
- R9: In status mode, reads at any address return a status word. Bit 7 is high only in the error state, bit 5 is the error flag, bit 3 is high once the erase has started, and all other bits are 0.
- R10: A successful erase returns to array-read mode by itself, with busy_o low.
- R11: If erase_fail_i is high in the last cycle of an erased block, the erase ends in an error state. That state shows status 0xA8 with busy_o low, ignores every write except data 0xF0, and returns to array reads on 0xF0.
- R12: After reset the block is in array-read mode with busy_o and suspend_req_o low. Each word at address a holds a XOR 0x5A.
- R13: The running phase lasts ERASE_CYC cycles per erased block plus one cycle per skipped block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Bus write strobe, one cycle per write |
| addr_i | input | ADDR_W | Bus word address for reads and writes |
| wdata_i | input | DW | Bus write data (command byte in the low 8 bits) |
| prot_i | input | NUM_BLK | Per-block protect bits |
| erase_fail_i | input | 1 | Array verify failure for the block being erased |
| rdata_o | output | DW | Read data: array word or status word |
| busy_o | output | 1 | Selection, erase or dwell in progress |
| suspend_req_o | output | 1 | One-cycle suspend request (stub) |

## Verification
On every cycle, the assertions check several things. The command decoder is cleared whenever it is not armed. The selection timer stays inside its window. The execution bitmap is frozen once the erase has run. An erased block reads all ones on the next cycle. Suspend requests never appear during a chip erase. The error state is held until a reset command. Other behaviours can only be shown by the bench's scenarios: the exact start cycle after a window restart, the run length in cycles, which blocks change or keep their data, and the all-protected dwell ending with the data intact.

// File: rtl/fe_pkg.sv
package fe_pkg;
  typedef enum logic [2:0] {ST_READ, ST_SEL, ST_RUN, ST_EMPTY, ST_ERR} fe_state_e;

  localparam logic [7:0] CMD_KEY1  = 8'hAA;
  localparam logic [7:0] CMD_KEY2  = 8'h55;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_BLOCK = 8'h30;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;
  localparam logic [7:0] CMD_RESET = 8'hF0;

  localparam int STAT_READY = 7;
  localparam int STAT_ERR   = 5;
  localparam int STAT_RUN   = 3;
endpackage

// File: rtl/fe_cmd_seq.sv
module fe_cmd_seq #(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] UNLOCK_A = 'h2A,
  parameter logic [ADDR_W-1:0] UNLOCK_B = 'h15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              armed_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        cmd_i,
  output logic              chip_go_o,
  output logic              blk_go_o
);
  import fe_pkg::*;

  logic [2:0]        step_q;
  logic [ADDR_W-1:0] exp_a;
  logic [7:0]        exp_d;
  logic              key_ok, fire;

  always_comb begin
    unique case (step_q)
      3'd0: begin exp_a = UNLOCK_A; exp_d = CMD_KEY1;  end
      3'd1: begin exp_a = UNLOCK_B; exp_d = CMD_KEY2;  end
      3'd2: begin exp_a = UNLOCK_A; exp_d = CMD_ERASE; end
      3'd3: begin exp_a = UNLOCK_A; exp_d = CMD_KEY1;  end
      3'd4: begin exp_a = UNLOCK_B; exp_d = CMD_KEY2;  end
      default: begin exp_a = UNLOCK_A; exp_d = CMD_CHIP; end
    endcase
  end

  assign key_ok    = (addr_i == exp_a) && (cmd_i == exp_d);
  assign fire      = armed_i && we_i && (step_q == 3'd5);
  assign chip_go_o = fire && (addr_i == UNLOCK_A) && (cmd_i == CMD_CHIP);
  assign blk_go_o  = fire && (cmd_i == CMD_BLOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     step_q <= '0;
    else if (!armed_i)               step_q <= '0;
    else if (we_i) begin
      if (step_q == 3'd5)            step_q <= '0;
      else if (key_ok)               step_q <= step_q + 3'd1;
      else                           step_q <= '0;
    end
  end

  p_seq_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> (step_q == 3'd0));
endmodule

// File: rtl/fe_array.sv
module fe_array #(
  parameter int ADDR_W = 6,
  parameter int DW     = 8,
  parameter int BLK_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_en_i,
  input  logic [BLK_W-1:0]  erase_blk_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DW-1:0]     rdata_o
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int BW    = 1 << (ADDR_W - BLK_W);

  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= DW'(i) ^ DW'(8'h5A);
    end else if (erase_en_i) begin
      for (int w = 0; w < BW; w++) mem_q[int'(erase_blk_i) * BW + w] <= '1;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  p_erase_ones_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_en_i |=> (mem_q[int'($past(erase_blk_i)) * BW + BW - 1] == '1));
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl #(
  parameter int ADDR_W       = 6,
  parameter int DW           = 8,
  parameter int NUM_BLK      = 8,
  parameter int TICKS_PER_US = 50,
  parameter int SEL_US       = 50,
  parameter int EMPTY_US     = 100,
  parameter int ERASE_CYC    = 64,
  parameter logic [ADDR_W-1:0] UNLOCK_A = 'h2A,
  parameter logic [ADDR_W-1:0] UNLOCK_B = 'h15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [NUM_BLK-1:0] prot_i,
  input  logic               erase_fail_i,
  output logic [DW-1:0]      rdata_o,
  output logic               busy_o,
  output logic               suspend_req_o
);
  import fe_pkg::*;

  localparam int BLK_W     = $clog2(NUM_BLK);
  localparam int SEL_CYC   = TICKS_PER_US * SEL_US;
  localparam int EMPTY_CYC = TICKS_PER_US * EMPTY_US;
  localparam int TW        = $clog2(SEL_CYC + 1);
  localparam int CNT_MAX   = (ERASE_CYC > EMPTY_CYC) ? ERASE_CYC : EMPTY_CYC;
  localparam int CW        = $clog2(CNT_MAX + 1);

  fe_state_e          state_q;
  logic [NUM_BLK-1:0] sel_q, run_q, blk_oh, start_src, start_map;
  logic [BLK_W-1:0]   idx_q, addr_blk;
  logic [TW-1:0]      tmr_q;
  logic [CW-1:0]      cnt_q;
  logic               err_q, chip_q, susp_q;
  logic [7:0]         cmd;
  logic               chip_go, blk_go, sel_add, start, run_sel, last_tick, erase_en;
  logic               stat_mode;
  logic [DW-1:0]      arr_data, status;

  assign cmd       = wdata_i[7:0];
  assign addr_blk  = addr_i[ADDR_W-1 -: BLK_W];
  assign blk_oh    = NUM_BLK'(1) << addr_blk;

  fe_cmd_seq #(.ADDR_W(ADDR_W), .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)) u_seq (
    .clk_i, .rst_ni,
    .armed_i  (state_q == ST_READ),
    .we_i, .addr_i,
    .cmd_i    (cmd),
    .chip_go_o(chip_go),
    .blk_go_o (blk_go)
  );

  assign sel_add   = (state_q == ST_SEL) && we_i && (cmd == CMD_BLOCK);
  assign start     = chip_go ||
                     ((state_q == ST_SEL) && (tmr_q == TW'(SEL_CYC - 1)) && !sel_add);
  assign start_src = (state_q == ST_READ) ? '1 : sel_q;
  assign start_map = start_src & ~prot_i;
  assign run_sel   = run_q[idx_q];
  assign last_tick = (cnt_q == CW'(ERASE_CYC - 1));
  assign erase_en  = (state_q == ST_RUN) && run_sel && last_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_READ;
      sel_q   <= '0;
      run_q   <= '0;
      idx_q   <= '0;
      tmr_q   <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      chip_q  <= 1'b0;
      susp_q  <= 1'b0;
    end else begin
      susp_q <= we_i && (cmd == CMD_SUSP) && !chip_q &&
                ((state_q == ST_SEL) || (state_q == ST_RUN));
      unique case (state_q)
        ST_READ: begin
          if (chip_go) chip_q <= 1'b1;
          else if (blk_go) begin
            chip_q  <= 1'b0;
            sel_q   <= blk_oh;
            tmr_q   <= '0;
            state_q <= ST_SEL;
          end
        end
        ST_SEL: begin
          if (sel_add) begin
            sel_q <= sel_q | blk_oh;
            tmr_q <= '0;
          end else tmr_q <= tmr_q + TW'(1);
        end
        ST_RUN: begin
          if (run_sel && !last_tick) cnt_q <= cnt_q + CW'(1);
          else begin
            cnt_q <= '0;
            if (run_sel && erase_fail_i) err_q <= 1'b1;
            if (idx_q == BLK_W'(NUM_BLK - 1))
              state_q <= (err_q || (run_sel && erase_fail_i)) ? ST_ERR : ST_READ;
            else idx_q <= idx_q + BLK_W'(1);
          end
        end
        ST_EMPTY: begin
          if (cnt_q == CW'(EMPTY_CYC - 1)) begin
            cnt_q   <= '0;
            state_q <= ST_READ;
          end else cnt_q <= cnt_q + CW'(1);
        end
        ST_ERR: begin
          if (we_i && (cmd == CMD_RESET)) begin
            err_q   <= 1'b0;
            state_q <= ST_READ;
          end
        end
        default: state_q <= ST_READ;
      endcase
      if (start) begin
        run_q   <= start_map;
        idx_q   <= '0;
        cnt_q   <= '0;
        err_q   <= 1'b0;
        state_q <= (|start_map) ? ST_RUN : ST_EMPTY;
      end
    end
  end

  fe_array #(.ADDR_W(ADDR_W), .DW(DW), .BLK_W(BLK_W)) u_array (
    .clk_i, .rst_ni,
    .erase_en_i (erase_en),
    .erase_blk_i(idx_q),
    .raddr_i    (addr_i),
    .rdata_o    (arr_data)
  );

  always_comb begin
    status             = '0;
    status[STAT_READY] = (state_q == ST_ERR);
    status[STAT_ERR]   = err_q;
    status[STAT_RUN]   = (state_q == ST_RUN) || (state_q == ST_EMPTY) || (state_q == ST_ERR);
  end

  assign stat_mode     = (state_q != ST_READ);
  assign rdata_o       = stat_mode ? status : arr_data;
  assign busy_o        = (state_q == ST_SEL) || (state_q == ST_RUN) || (state_q == ST_EMPTY);
  assign suspend_req_o = susp_q;

  p_busy_status_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (rdata_o[STAT_READY] == 1'b0));
  p_sel_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEL) |-> (int'(tmr_q) < SEL_CYC));
  p_no_add_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_RUN) && $past(state_q == ST_RUN)) |-> $stable(run_q));
  p_chip_no_susp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_q && (state_q == ST_RUN)) |-> !suspend_req_o);
  p_susp_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_req_o |-> $past(we_i));
  p_empty_exit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EMPTY) |=> ((state_q == ST_EMPTY) || (state_q == ST_READ)));
  p_err_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_ERR) && !(we_i && (cmd == CMD_RESET))) |=> (state_q == ST_ERR));
endmodule

// File: tb/tb_flash_erase_ctrl.sv
module tb_flash_erase_ctrl;
  localparam int AW = 6, DW = 8, NB = 8, BW = 8;
  localparam int SEL_CYC = 20, EMPTY_CYC = 10, ERASE_CYC = 8;
  localparam logic [5:0] KA = 6'h2A, KB = 6'h15;

  logic clk = 0, rst_n = 0, we = 0, efail = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic [NB-1:0] prot = '0;
  logic busy, susp;

  flash_erase_ctrl #(.ADDR_W(AW), .DW(DW), .NUM_BLK(NB), .TICKS_PER_US(1),
    .SEL_US(SEL_CYC), .EMPTY_US(EMPTY_CYC), .ERASE_CYC(ERASE_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .prot_i(prot), .erase_fail_i(efail), .rdata_o(rdata), .busy_o(busy),
    .suspend_req_o(susp));

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, n_cyc = 0;
  logic [DW-1:0] exp_mem [64];

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic good_key(int s);
    case (s)
      0: wr(KA, 8'hAA);
      1: wr(KB, 8'h55);
      2: wr(KA, 8'h80);
      3: wr(KA, 8'hAA);
      default: wr(KB, 8'h55);
    endcase
  endtask

  task automatic unlock5();
    for (int s = 0; s < 5; s++) good_key(s);
  endtask

  task automatic erase_model(int b);
    for (int w = 0; w < BW; w++) exp_mem[b*BW + w] = '1;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic sweep(string req);
    int bad = 0, act = 0, exp = 0;
    for (int a = 0; a < 64; a++) begin
      addr = AW'(a); #1;
      if (rdata !== exp_mem[a] && bad == 0) begin bad = 1; act = rdata; exp = exp_mem[a]; end
    end
    chk(req, act, exp);
  endtask

  typedef struct packed {logic [2:0] step; logic [5:0] a; logic [7:0] d; logic busy;} vec_t;
  localparam vec_t VEC [10] = '{
    '{3'd0, 6'h2A, 8'h55, 1'b0}, '{3'd0, 6'h15, 8'hAA, 1'b0},
    '{3'd1, 6'h2A, 8'h55, 1'b0}, '{3'd2, 6'h2A, 8'h90, 1'b0},
    '{3'd3, 6'h15, 8'hAA, 1'b0}, '{3'd4, 6'h2A, 8'h55, 1'b0},
    '{3'd5, 6'h2A, 8'h20, 1'b0}, '{3'd5, 6'h15, 8'h10, 1'b0},
    '{3'd5, 6'h2A, 8'h80, 1'b0}, '{3'd5, 6'h28, 8'h30, 1'b1}};

  initial begin
    int n;
    for (int i = 0; i < 64; i++) exp_mem[i] = DW'(i) ^ 8'h5A;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 busy", busy, 0);
    chk("R12 suspend", susp, 0);
    sweep("R12 initial array");

    // R2/R1 table of corrupted and valid sequences
    foreach (VEC[i]) begin
      for (int s = 0; s < int'(VEC[i].step); s++) good_key(s);
      wr(VEC[i].a, VEC[i].d);
      chk("R2 R1 busy after sequence", busy, VEC[i].busy);
      if (VEC[i].busy) begin
        wait_idle(n);
        erase_model(5);
        sweep("R1 block erase result");
      end else begin
        #1; chk("R2 array read", rdata, exp_mem[addr]);
      end
    end

    // R3/R4/R9/R13/R10 block list with window restart
    unlock5(); wr(6'h08, 8'h30);
    chk("R9 status while selecting", rdata, 8'h00);
    repeat (10) @(negedge clk);
    wr(6'h30, 8'h30);
    repeat (SEL_CYC - 1) @(negedge clk);
    chk("R3 not started before window end", rdata[3], 0);
    chk("R3 busy in window", busy, 1);
    @(negedge clk);
    chk("R3 started at window end", rdata, 8'h08);
    wr(6'h18, 8'h30);
    wait_idle(n);
    chk("R13 run length", n + 2, 2*ERASE_CYC + 6);
    erase_model(1); erase_model(6);
    chk("R10 busy low after erase", busy, 0);
    sweep("R4 R10 array after list erase");

    // R5 protection skip
    prot = 8'b0000_0100;
    unlock5(); wr(6'h10, 8'h30); wr(6'h20, 8'h30);
    wait_idle(n);
    erase_model(4);
    sweep("R5 protected block kept");

    // R6 all protected
    prot = 8'b1000_0001;
    unlock5(); wr(6'h00, 8'h30); wr(6'h38, 8'h30);
    repeat (SEL_CYC) @(negedge clk);
    chk("R6 status during dwell", rdata, 8'h08);
    wait_idle(n);
    chk("R6 dwell length", n, EMPTY_CYC);
    sweep("R6 data unchanged");

    // R8 suspend stub and ignored reset during block erase
    prot = '0;
    unlock5(); wr(6'h00, 8'h30);
    wr(6'h05, 8'hB0);
    chk("R8 suspend pulse", susp, 1);
    @(negedge clk);
    chk("R8 suspend one cycle", susp, 0);
    wr(6'h00, 8'hF0);
    chk("R8 reset ignored", busy, 1);
    wait_idle(n);
    erase_model(0);
    sweep("R8 erase continued");

    // R7 chip erase
    prot = 8'b0000_1000;
    unlock5(); wr(KA, 8'h10);
    chk("R7 chip started at once", rdata, 8'h08);
    wr(6'h00, 8'hF0);
    wr(6'h00, 8'hB0);
    chk("R7 no suspend in chip erase", susp, 0);
    chk("R7 reset ignored", busy, 1);
    wait_idle(n);
    chk("R13 chip run length", n + 4, 7*ERASE_CYC + 1);
    for (int b = 0; b < NB; b++) if (b != 3) erase_model(b);
    sweep("R7 chip erase result");

    // R11 error hold
    prot = '0; efail = 1;
    unlock5(); wr(6'h18, 8'h30);
    wait_idle(n);
    efail = 0;
    erase_model(3);
    chk("R11 error status", rdata, 8'hA8);
    chk("R11 busy low", busy, 0);
    wr(6'h18, 8'h30);
    wr(KA, 8'hAA);
    #1; chk("R11 error held", rdata, 8'hA8);
    wr(6'h00, 8'hF0);
    #1; chk("R11 reset restores read", rdata, exp_mem[0]);
    sweep("R11 array after error");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule